// File: doc/BRIEF.md
# Four-Valued Threshold-Literal Network

This block evaluates a programmable Boolean function of several four-valued input digits. Each digit is carried on two bits and holds a value from 0 to 3. First, each digit passes through its own conversion table, which maps the four input values to a signed value from -4 to 3. The converted digit then feeds a set of threshold literals. A literal is true when the converted value is strictly greater than a stored signed threshold. Literals are arranged as `N_BR` branches. Each branch is the AND of one literal per input digit, which is the series path. The network output is the OR of all branches, which is the parallel path. Rewriting the stored thresholds and tables changes the function that the same hardware computes.

Input digit vectors arrive on a valid/ready stream, and the one-bit result leaves on a second valid/ready stream. In the default registered variant (`REGISTERED = 1`), the output stage behaves like a precharged node. It reads 0 whenever it holds no result, and it captures the network value on the edge that accepts an input. A held result stays unchanged until the consumer takes it, and while the result is stalled the input is back-pressured. The input side is ready when the stage is empty or its result is being taken in the same cycle, so full throughput is possible. Thresholds and conversion entries are loaded through a plain write port.

Top module: `tl_network`

## Requirements
- R1: After reset, `out_valid` is 0 and `z` is 0. Every threshold resets to 3, so every literal is false and each accepted vector yields `z` = 0. Every conversion table resets to the identity.
- R2: A literal for input j in branch p is 1 exactly when the converted digit c, if non-negative, satisfies c > t in signed comparison, where t is the 3-bit two's-complement threshold.
- R3: A threshold of -1 (code 3'b111) makes its literal true for every non-negative converted value 0..3.
- R4: The network value is the OR over all branches of the AND of that branch's `N_IN` literals.
- R5: The conversion entry for input j and input value v is written with `cfg_tbl` = 1 and `cfg_addr` = j*4+v. Its 3-bit two's-complement content replaces the digit before comparison. Digit j occupies `in_digits[2*j+1:2*j]`.
- R6: A negative converted value, for example -1 (3'b111), forces every literal of that input to 0, whatever its threshold.
- R7: The threshold for branch p, input j is written with `cfg_tbl` = 0 and `cfg_addr` = p*N_IN+j. A write becomes effective from the following cycle. A vector accepted in the same cycle as a write still uses the old contents.
- R8: When `in_valid` and `in_ready` are both high at an edge, `out_valid` is 1 after that edge and `z` holds the network value for that vector.
- R9: Whenever `out_valid` is 0, `z` is 0. This is the precharge level.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `z` stay unchanged at the next edge.
- R11: `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 1 | 0 selects a threshold, 1 selects a conversion entry |
| cfg_addr | input | CFG_AW | Entry index |
| cfg_data | input | 3 | Two's-complement value to store |
| in_valid | input | 1 | Input digit vector valid |
| in_ready | output | 1 | Stage can accept a vector |
| in_digits | input | 2*N_IN | Packed four-valued digits, digit j at bits 2j+1:2j |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| z | output | 1 | Network result, 0 when no result is held |

## Verification
The hardest case to reach is the interaction of a forced-open conversion entry with a branch whose thresholds are all -1. Reaching it needs a branch that would otherwise be unconditionally true, plus a table entry rewritten to a negative code. The stimulus therefore first loads a fully open branch and sweeps every input pattern. It then poisons single conversion entries and sweeps again, while random back-pressure on `out_ready` exercises the held-result path. Configuration writes are also issued in the same cycle as accepted vectors, to pin down which contents those vectors see.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int DIGIT_W = 2;
  localparam int VAL_W   = 3;
  localparam int N_VALS  = 4;
  localparam logic [VAL_W-1:0] THR_RESET = 3'd3;
endpackage

// File: rtl/tl_cfg_store.sv
module tl_cfg_store
  import tl_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_BR = 4,
  parameter int AW   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_tbl,
  input  logic [AW-1:0]                cfg_addr,
  input  logic [VAL_W-1:0]             cfg_data,
  output logic [N_BR*N_IN*VAL_W-1:0]   thr_flat,
  output logic [N_IN*N_VALS*VAL_W-1:0] map_flat
);
  localparam int N_THR = N_BR * N_IN;
  localparam int N_MAP = N_IN * N_VALS;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [VAL_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= THR_RESET;
      else if (cfg_we && !cfg_tbl && cfg_addr == AW'(t))
        r <= cfg_data;
    end
    assign thr_flat[t*VAL_W +: VAL_W] = r;
  end

  for (genvar m = 0; m < N_MAP; m++) begin : g_map
    logic [VAL_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= VAL_W'(m % N_VALS);
      else if (cfg_we && cfg_tbl && cfg_addr == AW'(m))
        r <= cfg_data;
    end
    assign map_flat[m*VAL_W +: VAL_W] = r;
  end
endmodule

// File: rtl/tl_convert.sv
module tl_convert
  import tl_pkg::*;
(
  input  logic [DIGIT_W-1:0]        digit,
  input  logic [N_VALS*VAL_W-1:0]   table_in,
  output logic [VAL_W-1:0]          conv_val
);
  always_comb conv_val = table_in[int'(digit)*VAL_W +: VAL_W];
endmodule

// File: rtl/tl_literal.sv
module tl_literal
  import tl_pkg::*;
(
  input  logic [VAL_W-1:0] conv_val,
  input  logic [VAL_W-1:0] thr,
  output logic             hit
);
  logic open_path;
  assign open_path = conv_val[VAL_W-1];
  assign hit = !open_path && ($signed(conv_val) > $signed(thr));
endmodule

// File: rtl/tl_network.sv
module tl_network
  import tl_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int N_BR       = 4,
  parameter bit REGISTERED = 1'b1,
  localparam int CFG_AW    = $clog2((N_BR > N_VALS ? N_BR : N_VALS) * N_IN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_tbl,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [2:0]              cfg_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2*N_IN-1:0]       in_digits,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    z
);
  localparam int N_LIT = N_BR * N_IN;

  logic [N_LIT*VAL_W-1:0]        thr_flat;
  logic [N_IN*N_VALS*VAL_W-1:0]  map_flat;
  logic [VAL_W-1:0]              conv [N_IN];
  logic [N_LIT-1:0]              hit;
  logic [N_BR-1:0]               branch_on;
  logic                          net;

  tl_cfg_store #(.N_IN(N_IN), .N_BR(N_BR), .AW(CFG_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .thr_flat(thr_flat), .map_flat(map_flat)
  );

  for (genvar j = 0; j < N_IN; j++) begin : g_conv
    tl_convert u_conv (
      .digit(in_digits[j*DIGIT_W +: DIGIT_W]),
      .table_in(map_flat[j*N_VALS*VAL_W +: N_VALS*VAL_W]),
      .conv_val(conv[j])
    );
  end

  for (genvar p = 0; p < N_BR; p++) begin : g_br
    for (genvar j = 0; j < N_IN; j++) begin : g_lit
      tl_literal u_lit (
        .conv_val(conv[j]),
        .thr(thr_flat[(p*N_IN+j)*VAL_W +: VAL_W]),
        .hit(hit[p*N_IN+j])
      );
      // R3: a -1 threshold passes any valid converted digit
      a_r3_floor_open: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flat[(p*N_IN+j)*VAL_W +: VAL_W] == 3'b111 && !conv[j][VAL_W-1])
          |-> hit[p*N_IN+j]);
      // R6: a negative converted digit opens the path
      a_r6_forced_open: assert property (@(posedge clk) disable iff (!rst_n)
        conv[j][VAL_W-1] |-> !hit[p*N_IN+j]);
    end
    assign branch_on[p] = &hit[p*N_IN +: N_IN];
  end

  assign net = |branch_on;

  if (REGISTERED) begin : g_reg
    logic v_q, z_q;
    assign in_ready = !v_q || out_ready;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        z_q <= 1'b0;
      end else if (in_valid && in_ready) begin
        v_q <= 1'b1;
        z_q <= net;
      end else if (out_ready) begin
        v_q <= 1'b0;
        z_q <= 1'b0;
      end
    end
    assign out_valid = v_q;
    assign z         = z_q;

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(z)));
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign z         = in_valid && net;
  end

  a_r9_precharge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !z);
  a_r11_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (REGISTERED && !out_valid) |-> in_ready);
endmodule

// File: tb/tl_network_test.sv
module tl_network_test;
  localparam int N_IN = 4;
  localparam int N_BR = 4;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_tbl = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [2:0] cfg_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [2*N_IN-1:0] in_digits = '0;
  logic in_ready, out_valid, z;

  always #4 clk = ~clk;

  tl_network #(.N_IN(N_IN), .N_BR(N_BR), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_digits(in_digits), .out_valid(out_valid),
    .out_ready(out_ready), .z(z)
  );

  int thr [N_BR][N_IN];
  int cmap [N_IN][4];
  bit mv, mz;
  int n_vec = 0, n_bad = 0;
  string tag = "R1";

  function automatic int sx3(input logic [2:0] d);
    return (d >= 3'd4) ? int'(d) - 8 : int'(d);
  endfunction

  function automatic bit model_net(input logic [2*N_IN-1:0] x);
    bit any = 0;
    for (int p = 0; p < N_BR; p++) begin
      bit all = 1;
      for (int j = 0; j < N_IN; j++) begin
        int c = cmap[j][x[2*j +: 2]];
        if (!(c >= 0 && c > thr[p][j])) all = 0;
      end
      if (all) any = 1;
    end
    return any;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < N_BR; p++)
      for (int j = 0; j < N_IN; j++) thr[p][j] = 3;
    for (int j = 0; j < N_IN; j++)
      for (int v = 0; v < 4; v++) cmap[j][v] = v;
    mv = 0; mz = 0;
  endtask

  task automatic compare();
    bit er = !mv || out_ready;
    n_vec++;
    if (out_valid !== mv || z !== mz || in_ready !== er) begin
      n_bad++;
      $display("FAIL %s: valid/z/ready got %b%b%b expected %b%b%b",
               tag, out_valid, z, in_ready, mv, mz, er);
    end
  endtask

  // one clock: inputs already driven; model follows the edge, then compare
  task automatic tick();
    bit rdy;
    @(posedge clk);
    rdy = !mv || out_ready;
    if (in_valid && rdy) begin mv = 1; mz = model_net(in_digits); end
    else if (rdy) begin mv = 0; mz = 0; end
    if (cfg_we) begin
      if (!cfg_tbl) thr[int'(cfg_addr) / N_IN][int'(cfg_addr) % N_IN] = sx3(cfg_data);
      else cmap[int'(cfg_addr) / 4][int'(cfg_addr) % 4] = sx3(cfg_data);
    end
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input bit tbl, input int addr, input logic [2:0] d);
    cfg_we = 1; cfg_tbl = tbl; cfg_addr = AW'(addr); cfg_data = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic sweep(input int ready_mode);
    for (int x = 0; x < 256; x++) begin
      in_valid = 1; in_digits = 8'(x);
      out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom % 2);
      tick();
      while (mv && !out_ready) begin
        out_ready = 1'($urandom % 2);
        in_valid = 1;
        tick();
      end
    end
    in_valid = 0; out_ready = 1; tick();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; compare();
    out_ready = 1;
    for (int k = 0; k < 16; k++) begin
      in_valid = 1; in_digits = 8'($urandom); tick();
    end
    // R3: branch 0 fully open
    tag = "R3";
    for (int j = 0; j < N_IN; j++) wr(0, j, 3'b111);
    sweep(0);
    // R2/R4: mixed thresholds in two branches
    tag = "R2_R4";
    wr(0, 0, 3'd1); wr(0, 1, 3'd0); wr(0, 2, 3'd2); wr(0, 3, 3'b111);
    for (int j = 0; j < N_IN; j++) wr(0, N_IN + j, 3'(j % 3));
    sweep(0);
    // R5: reversal map on inputs 0 and 2
    tag = "R5";
    for (int v = 0; v < 4; v++) begin wr(1, v, 3'(3 - v)); wr(1, 8 + v, 3'(3 - v)); end
    sweep(0);
    // R6: forced-open entries under an all -1 branch
    tag = "R6";
    for (int j = 0; j < N_IN; j++) wr(0, 2*N_IN + j, 3'b111);
    wr(1, 1*4 + 2, 3'b111);
    wr(1, 3*4 + 0, 3'b110);
    sweep(0);
    // R10/R11: random back-pressure
    tag = "R10_R11";
    sweep(1);
    // R7: config writes in the same cycle as accepted vectors
    tag = "R7";
    for (int k = 0; k < 200; k++) begin
      in_valid = 1'($urandom % 4 != 0);
      in_digits = 8'($urandom);
      out_ready = 1'($urandom % 4 != 0);
      cfg_we = 1'($urandom % 2); cfg_tbl = 1'($urandom % 2);
      cfg_addr = AW'($urandom); cfg_data = 3'($urandom);
      tick();
    end
    cfg_we = 0;
    // R8/R9: randomized stream with random contents
    tag = "R8_R9";
    for (int k = 0; k < 600; k++) begin
      in_valid = 1'($urandom % 3 != 0);
      in_digits = 8'($urandom);
      out_ready = 1'($urandom % 3 != 0);
      tick();
    end
    // R1: reset mid-stream restores defaults
    tag = "R1";
    in_valid = 0; rst_n = 0; @(posedge clk); model_reset(); @(negedge clk);
    rst_n = 1; out_ready = 1;
    for (int k = 0; k < 16; k++) begin
      in_valid = 1; in_digits = 8'($urandom); tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule